// File: doc/BRIEF.md
# Edge-Latched Interrupt Source Controller

This block gathers six single-bit event sources into one interrupt request. Typical sources are handshake bits of parallel I/O ports and counter terminal outputs. Each source is first brought into the local clock domain, and then its rising edges are detected. A rising edge on a source that software has enabled sets that source's sticky status bit. The interrupt line is high while any status bit is set.

Software sees one byte-wide register location. A write to it loads the enable mask. A read from it returns the latched status. To acknowledge a source, software writes a mask with that source's bit cleared. This drops the latch in the same cycle. Software can then write the full mask back at once to rearm the source. No separate clear register exists.

Top module: `irq_latch_top`

## Requirements
- R1: After reset the enable mask is all zero, `rdData` reads 0x00 and `irq` is low.
- R2: Status bit i (i = 0..5) of `rdData` belongs to `srcIn[i]` and to no other input.
- R3: A rising edge on `srcIn[i]` while enable bit i is set makes bit i of `rdData` read 1. The bit is not yet set two clock edges after the input change and is set after the third edge, because of two synchroniser stages and one edge-detect stage.
- R4: A status bit stays set after its source falls or stays high. A source that is already high and does not rise again does not set the bit.
- R5: A rising edge that occurs while the source's enable bit is clear is lost. Enabling the source later does not latch it.
- R6: A write to the register loads `wrData[5:0]` as the enable mask. In the same clock edge it clears every status bit whose new enable bit is 0. Status bits whose enable bit stays 1 are kept.
- R7: After an acknowledge write clears a source, writing its enable bit back to 1 rearms it, and the next rising edge latches again.
- R8: `irq` is a registered OR of the status bits. It rises one clock after the first status bit is set and falls one clock after the last status bit is cleared.
- R9: `rdData[7:6]` always read 0, and values written to `wrData[7:6]` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 8 | Write data; bits 5:0 form the enable mask |
| srcIn | input | 6 | Asynchronous interrupt source levels |
| rdData | output | 8 | Latched status, upper two bits zero |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions check the following relations on every cycle. A status bit never stays set while its enable bit is clear. A status bit sets only when its enable was on and the edge detector pulsed. An acknowledge write leaves no bit outside the new mask. The edge pulses last a single cycle. `irq` rises only after a status bit was set, and it falls once status is empty. Other behaviour can only be shown by the bench's scenarios. These are the exact three-edge latency from a source change, the loss of an edge seen while disabled, rearming after an acknowledge, and the full sweep of all 64 enable masks with junk in the upper write bits.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int SRC_COUNT = 6;

  typedef struct packed {
    logic                 enWrite;
    logic [SRC_COUNT-1:0] newEnable;
    logic [SRC_COUNT-1:0] riseMask;
  } latchStrobes_t;
endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int REG_WIDTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_WIDTH-1:0] wrData,
  input  logic [SRC_COUNT-1:0] srcIn,
  output latchStrobes_t        strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SRC_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [SRC_COUNT-1:0] prevQ;
  logic                 unusedHigh;

  // Synchroniser chain, depth set by parameter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  // Reserved write bits carry no state
  assign unusedHigh = |wrData[REG_WIDTH-1:SRC_COUNT];

  always_comb begin
    strb.enWrite   = wrEn;
    strb.newEnable = wrData[SRC_COUNT-1:0];
    strb.riseMask  = syncQ[LAST] & ~prevQ;
  end

  // R4: an edge pulse never lasts two cycles in a row
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (strb.riseMask & $past(strb.riseMask)) == '0);
endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  latchStrobes_t        strb,
  output logic [SRC_COUNT-1:0] statusQ,
  output logic                 irqQ
);
  logic [SRC_COUNT-1:0] enableQ;
  logic [SRC_COUNT-1:0] statusNext;
  logic [SRC_COUNT-1:0] enableNext;

  always_comb begin
    statusNext = statusQ | (strb.riseMask & enableQ);
    enableNext = enableQ;
    if (strb.enWrite) begin
      enableNext = strb.newEnable;
      statusNext = statusNext & strb.newEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      enableQ <= enableNext;
      statusQ <= statusNext;
      irqQ    <= |statusQ;
    end
  end

  // R6: no latched bit survives without its enable
  a_r6_status_within_enable: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~enableQ) == '0);

  // R6: after a write, only bits of the written mask may remain
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.enWrite |=> (statusQ & ~$past(strb.newEnable)) == '0);

  // R3: a newly set bit needs an edge pulse in the previous cycle
  a_r3_set_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(strb.riseMask)) == '0);

  // R5: a newly set bit needs its enable in the previous cycle
  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(enableQ)) == '0);

  // R8: irq rises only after some status was held
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(|statusQ));

  // R8: empty status drops irq on the next cycle
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ == '0) |=> !irqQ);
endmodule

// File: rtl/irq_latch_top.sv
module irq_latch_top
  import irq_latch_pkg::*;
#(
  parameter int REG_WIDTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_WIDTH-1:0] wrData,
  input  logic [SRC_COUNT-1:0] srcIn,
  output logic [REG_WIDTH-1:0] rdData,
  output logic                 irq
);
  localparam int PAD = REG_WIDTH - SRC_COUNT;

  latchStrobes_t        strb;
  logic [SRC_COUNT-1:0] statusQ;

  irq_latch_ctrl #(
    .REG_WIDTH  (REG_WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrData(wrData),
    .srcIn (srcIn),
    .strb  (strb)
  );

  irq_latch_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .statusQ(statusQ),
    .irqQ   (irq)
  );

  assign rdData = {{PAD{1'b0}}, statusQ};
endmodule

// File: tb/irq_latch_top_tb.sv
module irq_latch_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [5:0] srcIn = 6'h00;
  logic [7:0] rdData;
  logic       irq;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_latch_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .srcIn(srcIn), .rdData(rdData), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    step(1);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    check("R1 status", rdData, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    srcIn = 6'h3F; step(4);
    check("R1 disabled after reset", rdData, 8'h00);
    srcIn = 6'h00; step(3);

    // R9 and R8 sweep over every mask, junk in the upper write bits
    for (int m = 0; m < 64; m++) begin
      regWrite(8'(m) | ((m % 2) ? 8'hC0 : 8'h40));
      srcIn = 6'h3F;
      step(2);
      check("R3 not yet latched", rdData, 8'h00);
      step(1);
      check("R3 R9 sweep latch", rdData, 8'(m));
      check("R8 irq low before reg", {7'd0, irq}, 8'h00);
      step(1);
      check("R8 irq high", {7'd0, irq}, (m != 0) ? 8'h01 : 8'h00);
      srcIn = 6'h00; step(3);
      check("R4 held after fall", rdData, 8'(m));
      regWrite(8'h00);
      check("R6 cleared by zero write", rdData, 8'h00);
      step(1);
      check("R8 irq low", {7'd0, irq}, 8'h00);
    end

    // R2 each bit maps to its own source
    regWrite(8'h3F);
    for (int i = 0; i < 6; i++) begin
      srcIn = 6'(1 << i); step(4);
      check("R2 bit map", rdData, 8'(1 << i));
      srcIn = 6'h00;
      regWrite(8'h00); regWrite(8'h3F); step(2);
    end

    // R4 level high without new edge
    srcIn = 6'h04; step(4);
    regWrite(8'h3B); regWrite(8'h3F); step(4);
    check("R4 level no relatch", rdData, 8'h00);
    srcIn = 6'h00; step(3);

    // R5 edge while disabled is lost
    regWrite(8'h00);
    srcIn = 6'h01; step(4);
    regWrite(8'h01); step(4);
    check("R5 lost edge", rdData, 8'h00);
    srcIn = 6'h00; step(3);

    // R6 partial acknowledge keeps other bits
    regWrite(8'h3F);
    srcIn = 6'h03; step(4);
    srcIn = 6'h00;
    check("R6 two latched", rdData, 8'h03);
    regWrite(8'h3D);
    check("R6 partial clear", rdData, 8'h01);
    step(1);
    check("R8 irq still high", {7'd0, irq}, 8'h01);

    // R7 acknowledge then rearm
    regWrite(8'h3C);
    check("R7 ack clears", rdData, 8'h00);
    regWrite(8'h3F);
    srcIn = 6'h01; step(4);
    check("R7 relatch after rearm", rdData, 8'h01);
    srcIn = 6'h00;
    regWrite(8'h00);
    check("R7 final clear", rdData, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule